// File: doc/BRIEF.md
# Multi-Key Vault Lock Controller

This controller decides whether a vault lock is released. Three officer key switches feed it: one principal key and two deputy keys. A fourth switch selects business hours or off hours, and each setting has its own access rule. In business hours the principal key opens the vault alone, and so do the two deputy keys turned together. In off hours the principal key must be joined by at least one deputy key.

Each switch passes through a two-flop synchronizer and a debouncer before the rule sees it. The debouncer needs a stable window of `DEB_CYCLES` clocks, about 10 ms at the 100 MHz system clock by default. A registered lock state drives three outputs: a red locked lamp, a blue business-hours lamp, and a bank of green lamps. The green lamps flash while the vault is open. A parameterized divider sets their half period to `BLINK_DIV` clocks, which gives a 2 Hz toggle by default.

Top module: `vault_lock_ctrl`

## Requirements
- R1: With the debounced hours switch high (business hours), the vault opens when the principal key is on, or when both deputy keys are on.
- R2: With the debounced hours switch low (off hours), the vault opens only when the principal key is on together with one or both deputy keys. The principal key alone, and the deputies alone or together, keep it shut.
- R3: `led_locked_o` is 1 while the vault is shut and 0 while it is open.
- R4: `led_business_o` follows the debounced hours switch: 1 for business hours, 0 for off hours.
- R5: While the vault is open, every bit of `led_green_o` carries the same value. The bank lights on the first open cycle, then toggles every `BLINK_DIV` clocks, so over any window of 4·`BLINK_DIV` open cycles it is lit for exactly 2·`BLINK_DIV` of them.
- R6: While the vault is shut, `led_green_o` is all zeros.
- R7: A switch level that changes and returns within fewer than `DEB_CYCLES` clocks has no effect on the lock or on the lamps.
- R8: The lock state is evaluated again every clock. The vault shuts on the cycle after the debounced inputs stop meeting the rule for the current hours setting, and this includes a change of the hours setting while the vault is open.
- R9: A synchronous active-high reset leaves the vault shut, with the green bank dark, the blue lamp off, and the blink counter and debouncers cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| hours_business_i | input | 1 | Hours switch: 1 business hours, 0 off hours (asynchronous) |
| key_principal_i | input | 1 | Principal officer key switch (asynchronous) |
| key_deputy_a_i | input | 1 | First deputy key switch (asynchronous) |
| key_deputy_b_i | input | 1 | Second deputy key switch (asynchronous) |
| led_locked_o | output | 1 | Red lamp, lit while shut |
| led_business_o | output | 1 | Blue lamp, lit in business hours |
| led_green_o | output | N_GREEN | Green lamp bank, flashing while open |

## Verification
A wrong rule evaluation shows on `led_locked_o` one clock after the debounced inputs settle, which is about `DEB_CYCLES`+4 clocks after a switch moves. Sweeping all sixteen combinations of switches exposes any wrong rule entry. A faulty debouncer shows up either as a lamp reacting to a short glitch or as a lamp that never follows a held level. A faulty divider or phase register shows within a few `BLINK_DIV` periods as a wrong duty, as bits of the green bank that disagree, or as green light while the vault is shut.

// File: rtl/vlk_pkg.sv
`timescale 1ns/1ps
package vlk_pkg;
  // Bit positions of the conditioned switch vector
  localparam int unsigned SW_BUSINESS  = 0;
  localparam int unsigned SW_PRINCIPAL = 1;
  localparam int unsigned SW_DEPUTY_A  = 2;
  localparam int unsigned SW_DEPUTY_B  = 3;
  localparam int unsigned SW_COUNT     = 4;

  typedef struct packed {
    logic deputy_b;
    logic deputy_a;
    logic principal;
    logic business;
  } vlk_switches_t;
endpackage

// File: rtl/vlk_input_cond.sv
`timescale 1ns/1ps
module vlk_input_cond #(
  parameter int unsigned DEB_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic          s1_q, s2_q, db_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      db_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != db_q) begin
        if (cnt_q == CNT_LAST) begin
          db_q  <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign clean_o = db_q;

  // R7
  db_holds_when_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_q == db_q) |=> $stable(db_q));
  // R7
  db_moves_after_window_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(db_q) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/vlk_access_rule.sv
`timescale 1ns/1ps
module vlk_access_rule
  import vlk_pkg::*;
(
  input  vlk_switches_t sw_i,
  output logic          open_ok_o
);
  logic both_deputies, any_deputy;

  always_comb begin
    both_deputies = sw_i.deputy_a & sw_i.deputy_b;
    any_deputy    = sw_i.deputy_a | sw_i.deputy_b;
    if (sw_i.business) open_ok_o = sw_i.principal | both_deputies;
    else               open_ok_o = sw_i.principal & any_deputy;
  end
endmodule

// File: rtl/vlk_blinker.sv
`timescale 1ns/1ps
module vlk_blinker #(
  parameter int unsigned BLINK_DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic phase_o
);
  localparam int unsigned CW = $clog2(BLINK_DIV + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  // R5
  blink_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);
  // R5
  phase_steady_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && cnt_q != CNT_LAST) |=> $stable(phase_q));
endmodule

// File: rtl/vault_lock_ctrl.sv
`timescale 1ns/1ps
module vault_lock_ctrl
  import vlk_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 1_000_000,
  parameter int unsigned BLINK_DIV  = 25_000_000,
  parameter int unsigned N_GREEN    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hours_business_i,
  input  logic               key_principal_i,
  input  logic               key_deputy_a_i,
  input  logic               key_deputy_b_i,
  output logic               led_locked_o,
  output logic               led_business_o,
  output logic [N_GREEN-1:0] led_green_o
);
  logic [SW_COUNT-1:0] raw_vec, clean_vec;
  vlk_switches_t       sw;
  logic                open_ok, unlocked_q, phase;

  assign raw_vec[SW_BUSINESS]  = hours_business_i;
  assign raw_vec[SW_PRINCIPAL] = key_principal_i;
  assign raw_vec[SW_DEPUTY_A]  = key_deputy_a_i;
  assign raw_vec[SW_DEPUTY_B]  = key_deputy_b_i;

  for (genvar i = 0; i < SW_COUNT; i++) begin : g_cond
    vlk_input_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
      .clk(clk), .rst(rst), .raw_i(raw_vec[i]), .clean_o(clean_vec[i])
    );
  end

  assign sw.business  = clean_vec[SW_BUSINESS];
  assign sw.principal = clean_vec[SW_PRINCIPAL];
  assign sw.deputy_a  = clean_vec[SW_DEPUTY_A];
  assign sw.deputy_b  = clean_vec[SW_DEPUTY_B];

  vlk_access_rule u_rule (.sw_i(sw), .open_ok_o(open_ok));

  always_ff @(posedge clk) begin
    if (rst) unlocked_q <= 1'b0;
    else     unlocked_q <= open_ok;
  end

  vlk_blinker #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst(rst), .run_i(unlocked_q), .phase_o(phase)
  );

  assign led_locked_o   = ~unlocked_q;
  assign led_business_o = sw.business;
  assign led_green_o    = {N_GREEN{unlocked_q & phase}};

  // R2
  offhours_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked_q && !$past(sw.business)) |->
      ($past(sw.principal) && ($past(sw.deputy_a) || $past(sw.deputy_b))));
  // R1
  business_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked_q && $past(sw.business)) |->
      ($past(sw.principal) || ($past(sw.deputy_a) && $past(sw.deputy_b))));
  // R6
  green_dark_when_shut_chk: assert property (@(posedge clk) disable iff (rst)
    led_locked_o |-> (led_green_o == '0));
  // R8
  relock_on_rule_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_ok) |=> led_locked_o);
endmodule

// File: tb/tb_vault_lock_ctrl.sv
`timescale 1ns/1ps
module tb_vault_lock_ctrl;
  localparam int unsigned DEB  = 4;
  localparam int unsigned DIV  = 3;
  localparam int unsigned NG   = 4;
  localparam int unsigned SETTLE = DEB + 8;

  // entry: {business, principal, deputy_a, deputy_b, expect_open}
  localparam logic [4:0] VEC [16] = '{
    5'b0_000_0, 5'b0_001_0, 5'b0_010_0, 5'b0_011_0,
    5'b0_100_0, 5'b0_101_1, 5'b0_110_1, 5'b0_111_1,
    5'b1_000_0, 5'b1_001_0, 5'b1_010_0, 5'b1_011_1,
    5'b1_100_1, 5'b1_101_1, 5'b1_110_1, 5'b1_111_1
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_i = 0, p_i = 0, a_i = 0, b_i = 0;
  logic locked, business;
  logic [NG-1:0] green;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vault_lock_ctrl #(.DEB_CYCLES(DEB), .BLINK_DIV(DIV), .N_GREEN(NG)) dut (
    .clk(clk), .rst(rst), .hours_business_i(bus_i), .key_principal_i(p_i),
    .key_deputy_a_i(a_i), .key_deputy_b_i(b_i), .led_locked_o(locked),
    .led_business_o(business), .led_green_o(green)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic bz, input logic p, input logic a, input logic b);
    bus_i = bz; p_i = p; a_i = a; b_i = b;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int on_cnt, mixed;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 locked", locked, 1);
    chk("R9 green", green, 0);
    chk("R9 blue", business, 0);

    // R1 R2 R3 R4 R6 rule sweep
    for (int v = 0; v < 16; v++) begin
      drive(VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1]);
      cycles(SETTLE);
      chk(VEC[v][4] ? "R1 rule" : "R2 rule", !locked, VEC[v][0]);
      chk("R3 red lamp", locked, !VEC[v][0]);
      chk("R4 blue lamp", business, VEC[v][4]);
      if (!VEC[v][0]) chk("R6 green dark", green, 0);
    end

    // R5 blink duty and uniform bank
    drive(1, 1, 0, 0);
    cycles(SETTLE);
    on_cnt = 0; mixed = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      if (green == {NG{1'b1}}) on_cnt++;
      else if (green != '0) mixed++;
      @(negedge clk);
    end
    chk("R5 lit cycles", on_cnt, 2 * DIV);
    chk("R5 uniform bank", mixed, 0);

    // R8 hours change while open relocks
    drive(0, 1, 0, 0);
    cycles(SETTLE);
    chk("R8 relock on mode change", locked, 1);
    chk("R6 green dark after relock", green, 0);

    // R7 glitch shorter than window ignored
    drive(1, 0, 0, 0);
    cycles(SETTLE);
    p_i = 1; cycles(2); p_i = 0;
    on_cnt = 0;
    for (int i = 0; i < SETTLE; i++) begin
      if (!locked) on_cnt++;
      @(negedge clk);
    end
    chk("R7 glitch ignored", on_cnt, 0);
    bus_i = 0; cycles(2); bus_i = 1;
    on_cnt = 0;
    for (int i = 0; i < SETTLE; i++) begin
      if (!business) on_cnt++;
      @(negedge clk);
    end
    chk("R7 mode glitch ignored", on_cnt, 0);

    // R9 reset while open
    drive(1, 1, 1, 1);
    cycles(SETTLE);
    chk("R1 open before reset", locked, 0);
    rst = 1'b1; @(negedge clk);
    chk("R9 reset relocks", locked, 1);
    chk("R9 reset darkens green", green, 0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule